// File: doc/BRIEF.md
# AUX Channel Transaction Sequencer

This block carries out a single transaction on a display auxiliary channel for a host. The transaction is either a native access or an I2C access tunnelled over AUX. The host presents a command nibble, a 20-bit target address, a byte count from 1 to 16 and up to sixteen bytes of write data, then pulses a start strobe. The sequencer claims the shared channel through a request/grant pair and waits, within a bounded number of polls, for the channel to report ready. It then issues the request on a link-side handshake port, which stands in for the physical line coder.

A deferring sink causes the request to be issued again, up to a fixed limit. Each reply is sampled only after a settle interval. On a read, the received byte count is compared with the requested one before any data is captured. Whatever the outcome, the sequencer hands the channel back, confirms that the grant has gone, and waits an exit interval before it signals completion. Completion is a single-cycle done pulse together with a result code.

In I2C mode the sequencer builds the command itself, from a read flag and a stop flag. A start-only request completes at once. An I2C-level DEFER triggers a pause followed by a full retry, and I2C-level ACK, NACK and invalid replies map to distinct results. All delays are counted in clock cycles, derived from a cycles-per-microsecond parameter.

Top module: `aux_txn_seq`

## Requirements
- R1: Bit 0 of the command gives the direction (1 = read, 0 = write); native reads use command 9 and native writes use command 8, and the link command equals the host command. For a write, the link write data holds the host bytes below the count and zero above it. For a read, the link write data is zero and `rdata_o` holds the received bytes below the count and zero above it. `rdata_o` is cleared when a transaction starts.
- R2: The link length field carries the byte count minus one, and a count of 16 gives 15.
- R3: Every link request is issued while the channel request is high. If the grant is not high one cycle after the request rises, the result is 1 (no grant) and no link request is issued.
- R4: The ready input is checked at most 3 times, with 100 us between checks. If it is still low after the third check, the result is 2 (busy) and no link request is issued.
- R5: A link reply whose AUX type field (`lnk_reply_i[1:0]`, 00 ACK, 01 NACK, 10 DEFER) is DEFER causes the request to be issued again. If 16 consecutive launches are all deferred, the result is 3 (defer limit); 15 DEFERs followed by an ACK give result 0.
- R6: The link request stays high until `lnk_done_i`. The reply is sampled no earlier than 400 us after `lnk_done_i`.
- R7: On a read whose received count differs from the requested count, the result is 4 (count mismatch) and `rdata_o` stays zero.
- R8: On every exit the channel request is dropped and the grant is checked one cycle later. If the grant is still high, the result is 5 (release failure). `done_o` follows 400 us after the release, and the channel request is low while `done_o` is high.
- R9: In I2C mode the link command is {0, MOT, 0, read}, with MOT (bit 2) set unless stop is requested, and the length field is 0.
- R10: An I2C start-only request pulses `done_o` with result 0 in the cycle after the start strobe and never raises the channel request.
- R11: In I2C mode, after a clean exit the I2C type field (`lnk_reply_i[3:2]`) decides the outcome. 00 ACK gives result 0; 01 NACK gives result 6; 11 gives result 7; 10 DEFER causes a 100 us pause and a complete retry, including a new acquire.
- R12: After reset `done_o`, `own_req_o`, `lnk_req_o`, `result_o` and `rdata_o` are zero. `done_o` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, one cycle |
| cmd_i | input | 4 | Native command nibble |
| addr_i | input | 20 | Target address |
| count_i | input | 5 | Byte count, 1 to 16 |
| wdata_i | input | 128 | Write bytes, byte 0 in bits 7:0 |
| i2c_mode_i | input | 1 | Build an I2C-over-AUX command |
| i2c_rd_i | input | 1 | I2C read |
| i2c_stop_i | input | 1 | I2C stop requested (clears MOT) |
| i2c_start_only_i | input | 1 | I2C start-only request |
| done_o | output | 1 | Completion pulse |
| result_o | output | 3 | Result code |
| reply_o | output | 4 | Last link reply type |
| rdata_o | output | 128 | Read bytes |
| own_req_o | output | 1 | Channel ownership request |
| own_grant_i | input | 1 | Channel ownership grant |
| chan_ready_i | input | 1 | Channel ready status |
| lnk_req_o | output | 1 | Link request, held until done |
| lnk_cmd_o | output | 4 | Link command |
| lnk_addr_o | output | 20 | Link address |
| lnk_len_o | output | 4 | Byte count minus one |
| lnk_wdata_o | output | 128 | Link write bytes |
| lnk_done_i | input | 1 | Link reply arrived |
| lnk_reply_i | input | 4 | {I2C type, AUX type} |
| lnk_rcount_i | input | 5 | Received byte count |
| lnk_rdata_i | input | 128 | Received bytes |

## Verification
The bench targets the retry edges. A sink that defers 15 times must still reach success, while 16 DEFERs must end in a defer-limit result. A design with an off-by-one in its retry counter swaps these two outcomes or shows the wrong launch count. It also drives a grant that never arrives, a grant that never leaves, a channel that never becomes ready and a read whose count is short. A sequencer that skipped the grant checks, the bounded poll or the count comparison would report success, launch anyway, or leak data into `rdata_o`. In I2C mode the bench checks the MOT bit against the stop flag, the immediate start-only completion, and full re-acquisition after an I2C DEFER; a design that retried without releasing would show too few ownership requests.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;

  typedef enum logic [2:0] {
    RES_OK             = 3'd0,
    RES_NOGRANT        = 3'd1,
    RES_BUSY           = 3'd2,
    RES_DEFER_LIMIT    = 3'd3,
    RES_COUNT_MISMATCH = 3'd4,
    RES_RELEASE_FAIL   = 3'd5,
    RES_I2C_NACK       = 3'd6,
    RES_I2C_BAD        = 3'd7
  } result_e;

  localparam logic [1:0] RPL_ACK   = 2'b00;
  localparam logic [1:0] RPL_NACK  = 2'b01;
  localparam logic [1:0] RPL_DEFER = 2'b10;
  localparam logic [1:0] RPL_BAD   = 2'b11;

  typedef enum logic [3:0] {
    S_IDLE, S_ACQ, S_ACQ_CHK, S_POLL, S_POLL_WAIT, S_LAUNCH, S_SETTLE,
    S_SAMPLE, S_REL, S_REL_CHK, S_EXIT_WAIT, S_I2C_WAIT, S_FIN
  } seq_state_e;

endpackage

// File: rtl/aux_req_builder.sv
module aux_req_builder #(
  parameter int ADDR_W    = 20,
  parameter int MAX_BYTES = 16,
  localparam int DATA_W   = MAX_BYTES * 8,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1),
  localparam int LEN_W    = $clog2(MAX_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic [3:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              i2c_mode_i,
  input  logic              i2c_rd_i,
  input  logic              i2c_stop_i,
  output logic [3:0]        cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [LEN_W-1:0]  len_m1_o,
  output logic              is_read_o,
  output logic              i2c_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] mask_o
);

  logic [3:0]        cmd_n;
  logic [CNT_W-1:0]  count_n;
  logic [DATA_W-1:0] mask_n;
  logic [DATA_W-1:0] wdata_n;

  // I2C command nibble: bit 2 = MOT, bit 0 = read
  always_comb begin
    if (i2c_mode_i) begin
      cmd_n   = {1'b0, ~i2c_stop_i, 1'b0, i2c_rd_i};
      count_n = CNT_W'(1);
    end else begin
      cmd_n   = cmd_i;
      count_n = count_i;
    end
  end

  for (genvar b = 0; b < MAX_BYTES; b++) begin : g_byte_mask
    assign mask_n[b*8 +: 8] = {8{count_n > CNT_W'(b)}};
  end

  assign wdata_n = cmd_n[0] ? '0 : (wdata_i & mask_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_o   <= '0;
      addr_o  <= '0;
      count_o <= CNT_W'(1);
      i2c_o   <= 1'b0;
      wdata_o <= '0;
      mask_o  <= '0;
    end else if (capture_i) begin
      cmd_o   <= cmd_n;
      addr_o  <= addr_i;
      count_o <= count_n;
      i2c_o   <= i2c_mode_i;
      wdata_o <= wdata_n;
      mask_o  <= mask_n;
    end
  end

  assign is_read_o = cmd_o[0];
  assign len_m1_o  = count_o[LEN_W-1:0] - LEN_W'(1);

  p_i2c_mot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_i && i2c_mode_i) |=> (cmd_o[2] == !$past(i2c_stop_i)) && (len_m1_o == '0))
    else $error("MOT or length wrong for I2C command");

endmodule

// File: rtl/aux_wait_timer.sv
module aux_wait_timer #(
  parameter int TMR_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [TMR_W-1:0] load_val_i,
  output logic             expired_o
);

  logic [TMR_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;

  assign cnt_en = load_i || (cnt_q != '0);

  always_comb begin
    if (load_i) cnt_n = load_val_i - TMR_W'(1);
    else        cnt_n = cnt_q - TMR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign expired_o = (cnt_q == '0);

  p_load_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !expired_o || ($past(load_val_i) == TMR_W'(1)))
    else $error("timer expired immediately after load");

endmodule

// File: rtl/aux_seq_ctrl.sv
module aux_seq_ctrl
  import aux_seq_pkg::*;
#(
  parameter int READY_POLLS = 3,
  parameter int DEFER_MAX   = 16,
  parameter int POLL_CYC    = 100,
  parameter int SETTLE_CYC  = 400,
  parameter int EXIT_CYC    = 400,
  parameter int I2C_CYC     = 100,
  parameter int TMR_W       = 12,
  parameter int CNT_W       = 5,
  localparam int PW         = $clog2(READY_POLLS + 1),
  localparam int DW         = $clog2(DEFER_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             i2c_mode_i,
  input  logic             i2c_start_only_i,
  input  logic             is_read_i,
  input  logic             i2c_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             own_grant_i,
  input  logic             chan_ready_i,
  input  logic             lnk_done_i,
  input  logic [3:0]       rpl_i,
  input  logic [CNT_W-1:0] rcount_i,
  input  logic             tmr_expired_i,
  output logic             capture_o,
  output logic             tmr_load_o,
  output logic [TMR_W-1:0] tmr_val_o,
  output logic             own_req_o,
  output logic             lnk_req_o,
  output logic             rpl_capture_o,
  output logic             rd_capture_o,
  output logic             done_o,
  output logic [2:0]       result_o
);

  seq_state_e    state_q, state_n;
  logic [PW-1:0] poll_q, poll_n;
  logic [DW-1:0] defer_q, defer_n;
  result_e       res_q, res_n;

  always_comb begin
    state_n       = state_q;
    poll_n        = poll_q;
    defer_n       = defer_q;
    res_n         = res_q;
    capture_o     = 1'b0;
    tmr_load_o    = 1'b0;
    tmr_val_o     = '0;
    rpl_capture_o = 1'b0;
    rd_capture_o  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          res_n = RES_OK;
          if (i2c_mode_i && i2c_start_only_i) begin
            state_n = S_FIN;
          end else begin
            capture_o = 1'b1;
            state_n   = S_ACQ;
          end
        end
      end
      S_ACQ: state_n = S_ACQ_CHK;
      S_ACQ_CHK: begin
        poll_n = '0;
        if (own_grant_i) begin
          state_n = S_POLL;
        end else begin
          res_n   = RES_NOGRANT;
          state_n = S_REL;
        end
      end
      S_POLL: begin
        if (chan_ready_i) begin
          defer_n = '0;
          state_n = S_LAUNCH;
        end else if (poll_q == PW'(READY_POLLS - 1)) begin
          res_n   = RES_BUSY;
          state_n = S_REL;
        end else begin
          poll_n     = poll_q + PW'(1);
          tmr_load_o = 1'b1;
          tmr_val_o  = TMR_W'(POLL_CYC);
          state_n    = S_POLL_WAIT;
        end
      end
      S_POLL_WAIT: if (tmr_expired_i) state_n = S_POLL;
      S_LAUNCH: begin
        if (lnk_done_i) begin
          rpl_capture_o = 1'b1;
          tmr_load_o    = 1'b1;
          tmr_val_o     = TMR_W'(SETTLE_CYC);
          state_n       = S_SETTLE;
        end
      end
      S_SETTLE: if (tmr_expired_i) state_n = S_SAMPLE;
      S_SAMPLE: begin
        if (rpl_i[1:0] == RPL_DEFER) begin
          if (defer_q == DW'(DEFER_MAX - 1)) begin
            res_n   = RES_DEFER_LIMIT;
            state_n = S_REL;
          end else begin
            defer_n = defer_q + DW'(1);
            state_n = S_LAUNCH;
          end
        end else if (is_read_i && (rcount_i != count_i)) begin
          res_n   = RES_COUNT_MISMATCH;
          state_n = S_REL;
        end else begin
          rd_capture_o = is_read_i;
          state_n      = S_REL;
        end
      end
      S_REL: state_n = S_REL_CHK;
      S_REL_CHK: begin
        if (own_grant_i) res_n = RES_RELEASE_FAIL;
        tmr_load_o = 1'b1;
        tmr_val_o  = TMR_W'(EXIT_CYC);
        state_n    = S_EXIT_WAIT;
      end
      S_EXIT_WAIT: begin
        if (tmr_expired_i) begin
          state_n = S_FIN;
          if (res_q == RES_OK && i2c_i) begin
            unique case (rpl_i[3:2])
              RPL_ACK:   res_n = RES_OK;
              RPL_NACK:  res_n = RES_I2C_NACK;
              RPL_DEFER: begin
                tmr_load_o = 1'b1;
                tmr_val_o  = TMR_W'(I2C_CYC);
                state_n    = S_I2C_WAIT;
              end
              default:   res_n = RES_I2C_BAD;
            endcase
          end
        end
      end
      S_I2C_WAIT: if (tmr_expired_i) state_n = S_ACQ;
      S_FIN: state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      poll_q  <= '0;
      defer_q <= '0;
      res_q   <= RES_OK;
    end else begin
      state_q <= state_n;
      poll_q  <= poll_n;
      defer_q <= defer_n;
      res_q   <= res_n;
    end
  end

  assign own_req_o = (state_q inside {S_ACQ, S_ACQ_CHK, S_POLL, S_POLL_WAIT,
                                      S_LAUNCH, S_SETTLE, S_SAMPLE});
  assign lnk_req_o = (state_q == S_LAUNCH);
  assign done_o    = (state_q == S_FIN);
  assign result_o  = res_q;

  p_poll_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    poll_q < PW'(READY_POLLS)) else $error("ready poll count out of range");

  p_defer_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    defer_q < DW'(DEFER_MAX)) else $error("defer count out of range");

  p_start_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && start_i && i2c_mode_i && i2c_start_only_i)
      |=> done_o && (result_o == RES_OK) && !own_req_o)
    else $error("start-only request did not complete at once");

endmodule

// File: rtl/aux_txn_seq.sv
module aux_txn_seq
  import aux_seq_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int MAX_BYTES   = 16,
  parameter int CLK_PER_US  = 100,
  parameter int READY_POLLS = 3,
  parameter int DEFER_MAX   = 16,
  parameter int POLL_GAP_US = 100,
  parameter int SETTLE_US   = 400,
  parameter int EXIT_US     = 400,
  parameter int I2C_GAP_US  = 100,
  localparam int DATA_W     = MAX_BYTES * 8,
  localparam int CNT_W      = $clog2(MAX_BYTES + 1),
  localparam int LEN_W      = $clog2(MAX_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [3:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              i2c_mode_i,
  input  logic              i2c_rd_i,
  input  logic              i2c_stop_i,
  input  logic              i2c_start_only_i,
  output logic              done_o,
  output logic [2:0]        result_o,
  output logic [3:0]        reply_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              own_req_o,
  input  logic              own_grant_i,
  input  logic              chan_ready_i,
  output logic              lnk_req_o,
  output logic [3:0]        lnk_cmd_o,
  output logic [ADDR_W-1:0] lnk_addr_o,
  output logic [LEN_W-1:0]  lnk_len_o,
  output logic [DATA_W-1:0] lnk_wdata_o,
  input  logic              lnk_done_i,
  input  logic [3:0]        lnk_reply_i,
  input  logic [CNT_W-1:0]  lnk_rcount_i,
  input  logic [DATA_W-1:0] lnk_rdata_i
);

  localparam int GAP_MAX_US = (POLL_GAP_US > I2C_GAP_US) ? POLL_GAP_US : I2C_GAP_US;
  localparam int HLD_MAX_US = (SETTLE_US > EXIT_US) ? SETTLE_US : EXIT_US;
  localparam int LONG_US    = (GAP_MAX_US > HLD_MAX_US) ? GAP_MAX_US : HLD_MAX_US;
  localparam int TMR_W      = $clog2(LONG_US * CLK_PER_US + 1);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              capture, tmr_load, tmr_expired, rpl_cap, rd_cap;
  logic [TMR_W-1:0]  tmr_val;
  logic [CNT_W-1:0]  count_q;
  logic              is_read, i2c_q;
  logic [DATA_W-1:0] mask_q;

  aux_req_builder #(.ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES)) u_builder (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .capture_i  (capture),
    .cmd_i      (cmd_i),
    .addr_i     (addr_i),
    .count_i    (count_i),
    .wdata_i    (wdata_i),
    .i2c_mode_i (i2c_mode_i),
    .i2c_rd_i   (i2c_rd_i),
    .i2c_stop_i (i2c_stop_i),
    .cmd_o      (lnk_cmd_o),
    .addr_o     (lnk_addr_o),
    .count_o    (count_q),
    .len_m1_o   (lnk_len_o),
    .is_read_o  (is_read),
    .i2c_o      (i2c_q),
    .wdata_o    (lnk_wdata_o),
    .mask_o     (mask_q)
  );

  aux_wait_timer #(.TMR_W(TMR_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_expired)
  );

  // link reply holding registers
  logic [3:0]        rpl_q, rpl_n;
  logic [CNT_W-1:0]  rcnt_q;
  logic [DATA_W-1:0] lrd_q;
  logic [DATA_W-1:0] rdata_q, rdata_n;
  logic              rdata_en;

  aux_seq_ctrl #(
    .READY_POLLS (READY_POLLS),
    .DEFER_MAX   (DEFER_MAX),
    .POLL_CYC    (POLL_GAP_US * CLK_PER_US),
    .SETTLE_CYC  (SETTLE_US * CLK_PER_US),
    .EXIT_CYC    (EXIT_US * CLK_PER_US),
    .I2C_CYC     (I2C_GAP_US * CLK_PER_US),
    .TMR_W       (TMR_W),
    .CNT_W       (CNT_W)
  ) u_ctrl (
    .clk              (clk),
    .rst_n            (rst_int_n),
    .start_i          (start_i),
    .i2c_mode_i       (i2c_mode_i),
    .i2c_start_only_i (i2c_start_only_i),
    .is_read_i        (is_read),
    .i2c_i            (i2c_q),
    .count_i          (count_q),
    .own_grant_i      (own_grant_i),
    .chan_ready_i     (chan_ready_i),
    .lnk_done_i       (lnk_done_i),
    .rpl_i            (rpl_q),
    .rcount_i         (rcnt_q),
    .tmr_expired_i    (tmr_expired),
    .capture_o        (capture),
    .tmr_load_o       (tmr_load),
    .tmr_val_o        (tmr_val),
    .own_req_o        (own_req_o),
    .lnk_req_o        (lnk_req_o),
    .rpl_capture_o    (rpl_cap),
    .rd_capture_o     (rd_cap),
    .done_o           (done_o),
    .result_o         (result_o)
  );

  always_comb begin
    rpl_n    = rpl_q;
    rdata_n  = rdata_q;
    rdata_en = capture || rd_cap;
    if (capture) begin
      rpl_n   = '0;
      rdata_n = '0;
    end
    if (rpl_cap) rpl_n = lnk_reply_i;
    if (rd_cap)  rdata_n = lrd_q & mask_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rpl_q   <= '0;
      rcnt_q  <= '0;
      lrd_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (capture || rpl_cap) rpl_q <= rpl_n;
      if (rpl_cap) begin
        rcnt_q <= lnk_rcount_i;
        lrd_q  <= lnk_rdata_i;
      end
      if (rdata_en) rdata_q <= rdata_n;
    end
  end

  assign reply_o = rpl_q;
  assign rdata_o = rdata_q;

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (lnk_req_o && !lnk_done_i) |=> lnk_req_o)
    else $error("link request dropped before reply");

  p_launch_owned_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    lnk_req_o |-> own_req_o)
    else $error("link request without channel ownership");

  p_done_released_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |-> !own_req_o && !lnk_req_o)
    else $error("done while channel still owned");

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |=> !done_o)
    else $error("done held longer than one cycle");

endmodule

// File: tb/aux_txn_seq_tb_top.sv
`timescale 1ns/1ps
module aux_txn_seq_tb_top;

  localparam int CPU = 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start, i2c_mode, i2c_rd, i2c_stop, i2c_so;
  logic [3:0]   cmd;
  logic [19:0]  addr;
  logic [4:0]   count;
  logic [127:0] wdata;
  logic         done, own_req, grant, ready, lnk_req, lnk_done;
  logic [2:0]   result;
  logic [3:0]   reply, lnk_cmd, lnk_len, lnk_reply;
  logic [127:0] rdata, lnk_wdata, lnk_rdata;
  logic [19:0]  lnk_addr;
  logic [4:0]   lnk_rcount;

  always #2.5 clk = ~clk;

  aux_txn_seq #(.CLK_PER_US(CPU)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cmd_i(cmd), .addr_i(addr),
    .count_i(count), .wdata_i(wdata), .i2c_mode_i(i2c_mode), .i2c_rd_i(i2c_rd),
    .i2c_stop_i(i2c_stop), .i2c_start_only_i(i2c_so), .done_o(done),
    .result_o(result), .reply_o(reply), .rdata_o(rdata), .own_req_o(own_req),
    .own_grant_i(grant), .chan_ready_i(ready), .lnk_req_o(lnk_req),
    .lnk_cmd_o(lnk_cmd), .lnk_addr_o(lnk_addr), .lnk_len_o(lnk_len),
    .lnk_wdata_o(lnk_wdata), .lnk_done_i(lnk_done), .lnk_reply_i(lnk_reply),
    .lnk_rcount_i(lnk_rcount), .lnk_rdata_i(lnk_rdata)
  );

  int tests = 0, fails = 0, cyc = 0, launches = 0, own_rises = 0;
  int last_done_cyc = 0, t0 = 0, t_done = 0, wait_n = 0;
  bit grant_block = 0, grant_stuck = 0, finished = 0, own_prev = 0;
  logic [3:0]   script [0:31];
  logic [4:0]   sink_rcount;
  logic [127:0] sink_rdata;
  logic [3:0]   rec_cmd, rec_len;
  logic [19:0]  rec_addr;
  logic [127:0] rec_wdata;

  always @(posedge clk) begin
    cyc++;
    if (own_req && !own_prev) own_rises++;
    own_prev <= own_req;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) grant <= 1'b0;
    else        grant <= grant_stuck ? 1'b1 : (grant_block ? 1'b0 : own_req);
  end

  // sink model on the link handshake port
  initial begin
    lnk_done = 0; lnk_reply = 0; lnk_rcount = 0; lnk_rdata = 0;
    forever begin
      @(negedge clk);
      if (lnk_req) begin
        int idx;
        idx = launches;
        launches++;
        rec_cmd = lnk_cmd; rec_len = lnk_len; rec_addr = lnk_addr; rec_wdata = lnk_wdata;
        repeat (2) @(negedge clk);
        lnk_reply  = script[idx > 31 ? 31 : idx];
        lnk_rcount = sink_rcount;
        lnk_rdata  = sink_rdata;
        lnk_done   = 1'b1;
        last_done_cyc = cyc;
        @(negedge clk);
        lnk_done = 1'b0;
      end
    end
  end

  function automatic logic [127:0] keep_bytes(logic [127:0] d, int n);
    logic [127:0] r;
    r = d;
    for (int b = 0; b < 16; b++) if (b >= n) r[b*8 +: 8] = 8'h00;
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_script(input int ndefer, input logic [3:0] defer_code, input logic [3:0] last_code);
    for (int i = 0; i < 32; i++) script[i] = (i < ndefer) ? defer_code : last_code;
  endtask

  task automatic run_txn(input logic [3:0] c, input logic [19:0] a, input logic [4:0] n,
                         input logic [127:0] wd, input bit i2c, input bit rd,
                         input bit stp, input bit so);
    @(negedge clk);
    cmd = c; addr = a; count = n; wdata = wd;
    i2c_mode = i2c; i2c_rd = rd; i2c_stop = stp; i2c_so = so;
    launches = 0; own_rises = 0;
    start = 1'b1; t0 = cyc;
    @(negedge clk);
    start = 1'b0;
    wait_n = 0;
    while (!done && wait_n < 40000) begin
      @(negedge clk);
      wait_n++;
    end
    t_done = cyc;
    if (!done) chk(0, "timeout waiting for done", 0, 1);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0]   c;
    logic [4:0]   n;
    logic [19:0]  a;
    logic [127:0] wd, sd;
    int           nd;
    void'($urandom(32'd20240611));
    rst_n = 0; start = 0; cmd = 0; addr = 0; count = 1; wdata = 0;
    i2c_mode = 0; i2c_rd = 0; i2c_stop = 0; i2c_so = 0; ready = 1;
    sink_rcount = 0; sink_rdata = 0;
    set_script(0, 4'h0, 4'h0);
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R12 reset state
    chk(!done && !own_req && !lnk_req && result == 0 && rdata == 0, "R12 reset state",
        {done, own_req, lnk_req, result}, 0);

    // R1 R2 directed write, 4 bytes
    wd = 128'hffeeddccbbaa99887766554433221100;
    set_script(0, 4'h0, 4'h0);
    run_txn(4'd8, 20'h00202, 5'd4, wd, 0, 0, 0, 0);
    chk(result == 0, "R1 write result", result, 0);
    chk(rec_cmd == 4'd8 && rec_len == 4'd3, "R2 write cmd/len", {rec_cmd, rec_len}, {4'd8, 4'd3});
    chk(rec_wdata == keep_bytes(wd, 4), "R1 write data masked", rec_wdata, keep_bytes(wd, 4));

    // R1 R2 directed read, 16 bytes
    sd = {$urandom, $urandom, $urandom, $urandom};
    sink_rcount = 5'd16; sink_rdata = sd;
    run_txn(4'd9, 20'h00100, 5'd16, wd, 0, 0, 0, 0);
    chk(result == 0 && rdata == sd, "R1 full read data", rdata, sd);
    chk(rec_len == 4'd15 && rec_wdata == 0, "R2 length 16 field", rec_len, 15);

    // R1 R2 R5 random native traffic with a few defers
    for (int k = 0; k < 12; k++) begin
      c  = ($urandom % 2) ? 4'd9 : 4'd8;
      n  = 5'(1 + $urandom % 16);
      a  = 20'($urandom);
      wd = {$urandom, $urandom, $urandom, $urandom};
      sd = {$urandom, $urandom, $urandom, $urandom};
      nd = $urandom % 4;
      set_script(nd, 4'b0010, 4'b0000);
      sink_rcount = n; sink_rdata = sd;
      run_txn(c, a, n, wd, 0, 0, 0, 0);
      chk(result == 0 && launches == nd + 1, "R5 random launches", launches, nd + 1);
      chk(rec_cmd == c && rec_addr == a && rec_len == 4'(n - 1), "R2 random request fields",
          {rec_cmd, rec_addr, rec_len}, {c, a, 4'(n - 1)});
      if (c[0]) chk(rdata == keep_bytes(sd, n), "R1 random read data", rdata, keep_bytes(sd, n));
      else      chk(rec_wdata == keep_bytes(wd, n) && rdata == 0, "R1 random write data",
                    rec_wdata, keep_bytes(wd, n));
    end

    // R5 15 defers then ACK
    set_script(15, 4'b0010, 4'b0000);
    sink_rcount = 5'd2;
    run_txn(4'd9, 20'h1, 5'd2, 0, 0, 0, 0, 0);
    chk(result == 0 && launches == 16, "R5 fifteen defers", {result, 8'(launches)}, {3'd0, 8'd16});

    // R5 16 defers
    set_script(32, 4'b0010, 4'b0010);
    run_txn(4'd8, 20'h1, 5'd2, 0, 0, 0, 0, 0);
    chk(result == 3 && launches == 16, "R5 defer limit", {result, 8'(launches)}, {3'd3, 8'd16});

    // R6 R8 settle and exit timing, release state
    set_script(0, 4'h0, 4'h0);
    run_txn(4'd8, 20'h3, 5'd1, 0, 0, 0, 0, 0);
    chk(t_done - last_done_cyc >= (400 + 400) * CPU, "R6 settle plus exit delay",
        t_done - last_done_cyc, (400 + 400) * CPU);
    chk(!own_req && done, "R8 channel released at done", own_req, 0);

    // R3 no grant
    grant_block = 1;
    run_txn(4'd8, 20'h3, 5'd1, 0, 0, 0, 0, 0);
    chk(result == 1 && launches == 0, "R3 no grant", {result, 8'(launches)}, {3'd1, 8'd0});
    grant_block = 0;

    // R4 never ready
    ready = 0;
    run_txn(4'd9, 20'h3, 5'd1, 0, 0, 0, 0, 0);
    chk(result == 2 && launches == 0, "R4 busy", {result, 8'(launches)}, {3'd2, 8'd0});
    chk(t_done - t0 >= (2 * 100 + 400) * CPU, "R4 poll spacing", t_done - t0, (2 * 100 + 400) * CPU);
    ready = 1;

    // R7 count mismatch after a good read
    sink_rcount = 5'd8; sink_rdata = {4{32'hA5A5_5A5A}};
    run_txn(4'd9, 20'h10, 5'd8, 0, 0, 0, 0, 0);
    chk(rdata != 0, "R7 setup read", rdata, 1);
    sink_rcount = 5'd7;
    run_txn(4'd9, 20'h10, 5'd8, 0, 0, 0, 0, 0);
    chk(result == 4 && rdata == 0, "R7 count mismatch", {result, rdata[7:0]}, {3'd4, 8'd0});

    // R8 grant stuck on release
    grant_stuck = 1;
    run_txn(4'd8, 20'h10, 5'd1, 0, 0, 0, 0, 0);
    chk(result == 5 && !own_req, "R8 release failure", result, 5);
    grant_stuck = 0;
    repeat (3) @(negedge clk);

    // R9 I2C command forms
    set_script(0, 4'h0, 4'h0);
    run_txn(4'd0, 20'h50, 5'd9, 128'h5a, 1, 0, 0, 0);
    chk(result == 0 && rec_cmd == 4'b0100 && rec_len == 0, "R9 I2C write with MOT",
        {rec_cmd, rec_len}, {4'b0100, 4'd0});
    sink_rcount = 5'd1; sink_rdata = 128'h1234;
    run_txn(4'd0, 20'h50, 5'd1, 0, 1, 1, 1, 0);
    chk(rec_cmd == 4'b0001 && rdata == 128'h34, "R9 I2C read with stop", {rec_cmd, rdata[7:0]},
        {4'b0001, 8'h34});

    // R10 start-only
    run_txn(4'd0, 20'h50, 5'd1, 0, 1, 0, 0, 1);
    chk(wait_n == 0 && result == 0 && launches == 0 && own_rises == 0, "R10 start-only",
        wait_n, 0);

    // R11 I2C NACK, invalid, DEFER
    set_script(0, 4'h0, 4'b0100);
    run_txn(4'd0, 20'h50, 5'd1, 0, 1, 0, 1, 0);
    chk(result == 6, "R11 I2C NACK", result, 6);
    set_script(0, 4'h0, 4'b1100);
    run_txn(4'd0, 20'h50, 5'd1, 0, 1, 0, 1, 0);
    chk(result == 7, "R11 I2C invalid reply", result, 7);
    set_script(2, 4'b1000, 4'b0000);
    run_txn(4'd0, 20'h50, 5'd1, 0, 1, 0, 1, 0);
    chk(result == 0 && launches == 3 && own_rises == 3, "R11 I2C defer retry",
        {8'(launches), 8'(own_rises)}, {8'd3, 8'd3});

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule